// File: doc/BRIEF.md
# Configurable Data Cache Controller

This block is a 4 KB data cache placed between a processor's load/store port and a single external memory bus. Each request brings two attributes from a separate region checker: whether the address may be cached, and whether a cached write should be kept in the cache (write-back) or also sent to memory at once (write-through). A cacheable read miss loads a full four-word line. If the chosen victim line holds modified data, that data is written out first. Accesses marked non-cacheable, and writes that miss, go directly to memory as single-word transfers.

The storage holds 4 sets of 64 ways, with 16-byte lines. Software writes one configuration register. That register selects the victim policy (pseudo-random or per-set round-robin) and sets a lock base. Ways with an index below the lock base are never replaced, so locking works in steps of 1/64 of the capacity. A global invalidate input clears every line in one cycle.

A request is a single-cycle `cpu_req` pulse issued while the block is idle. Completion is a single-cycle `cpu_ack` pulse. The memory side holds `mem_req` until each word is acknowledged.

Top module: `cfg_dcache`

## Requirements
- R1: A cacheable read that hits returns the addressed word with no external transfer, and `cpu_ack` pulses for one cycle two clock edges after the request edge. The address is decoded as follows: word = addr[3:2], set = addr[5:4], tag = addr[31:6].
- R2: A cacheable read miss reads the whole line from memory. This is four single-word reads at the line base, words 0 to 3 in ascending order. The request returns the addressed word, and later reads of that line hit.
- R3: A cacheable write hit with the write-back attribute updates only the cached word. It makes no external transfer and marks the line as modified.
- R4: When the chosen victim is valid and modified, four writes of its words 0 to 3 in ascending order go to its old address before the fill reads start. A clean victim is dropped without any write.
- R5: A cacheable write hit with the write-through attribute updates the cached word and issues exactly one external write. The line stays clean, so evicting it later causes no write.
- R6: A cacheable write miss issues one external write and allocates nothing, so a read of the same address afterwards misses.
- R7: A non-cacheable read or write makes exactly one external transfer and never allocates. Repeating the read goes to memory again.
- R8: In round-robin mode (config bit 6 = 0), each set has a pointer that is 0 after reset. The victim is the larger of the pointer and the lock base. After each fill the pointer moves to victim+1, and it wraps from way 63 back to the lock base.
- R9: In random mode (config bit 6 = 1), the victim comes from a free-running LFSR and is forced to lie at or above the lock base. With lock base 63, way 63 is always the victim.
- R10: Config bits 5:0 hold the lock base. Lines in ways below it are never replaced. After reset the register is zero, which means round-robin with no locking.
- R11: `inv_all` clears every valid and modified bit in one cycle, and modified data is discarded. If it coincides with the last word of a fill, the invalidate wins, but the requested word is still returned.
- R12: `mem_req` keeps address, direction and write data stable until `mem_ack`, and each acknowledge moves one word.
- R13: After reset, `cpu_ack` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | One-cycle request strobe, taken only when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| attr_cacheable | input | 1 | Region allows caching |
| attr_wback | input | 1 | 1 = write-back, 0 = write-through for cached writes |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 7 | Bit 6 random policy, bits 5:0 lock base |
| inv_all | input | 1 | Invalidate every line |
| mem_req | output | 1 | External transfer request |
| mem_we | output | 1 | External transfer is a write |
| mem_addr | output | 32 | External word address |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data, valid with `mem_ack` |
| mem_ack | input | 1 | External word acknowledge |

## Verification
The global invalidate and the completion of a line fill can happen in the same cycle, and when they do the invalidate must win. The memory model in the bench can be armed to raise `inv_all` on the same edge that it delivers the last word of a burst. The case is judged at the ports. The requested word must still arrive correctly. A repeat read of the same address must then go out as a fresh four-read fill, which shows that the line was not left valid.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_MWR,
    ST_MRD
  } dc_state_e;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Galois shift register step
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
  endfunction

  // Raise a random candidate into the unlocked range
  function automatic int unsigned rand_pick(input int unsigned cand, input int unsigned lock);
    return (cand >= lock) ? cand : (cand | lock);
  endfunction

  // Round-robin victim from pointer and lock base
  function automatic int unsigned rr_pick(input int unsigned ptr, input int unsigned lock);
    return (ptr >= lock) ? ptr : lock;
  endfunction

  // Pointer after a fill: wrap from the top way back to the lock base
  function automatic int unsigned rr_next(input int unsigned v, input int unsigned lock,
                                          input int unsigned nways);
    return (v + 1 >= nways) ? lock : v + 1;
  endfunction

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 64,
  parameter int TAG_W    = 26,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  input  logic [WAY_W-1:0] vq_way,
  output logic             vq_valid,
  output logic             vq_dirty,
  output logic [TAG_W-1:0] vq_tag,
  input  logic             inst_en,
  input  logic [WAY_W-1:0] inst_way,
  input  logic [TAG_W-1:0] inst_tag,
  input  logic             drt_en,
  input  logic [WAY_W-1:0] drt_way,
  output logic             any_valid
);

  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0] dirty_q [NUM_SETS];
  logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] match;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (match[w]) lk_way = WAY_W'(w);
    end
  end
  assign lk_hit = |match;

  assign vq_valid = valid_q[lk_set][vq_way];
  assign vq_dirty = dirty_q[lk_set][vq_way];
  assign vq_tag   = tag_q[lk_set][vq_way];

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  // Invalidate takes priority over a line install in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (inv_all) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (inst_en) begin
        valid_q[lk_set][inst_way] <= 1'b1;
        dirty_q[lk_set][inst_way] <= 1'b0;
      end
      if (drt_en) dirty_q[lk_set][drt_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[lk_set][inst_way] <= inst_tag;
  end

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int NUM_SETS   = 4,
  parameter int NUM_WAYS   = 64,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int WRD_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  set_i,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WRD_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WRD_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] line_q [NUM_SETS][NUM_WAYS][LINE_WORDS];

  assign rd_data = line_q[set_i][rd_way][rd_word];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[set_i][wr_way][wr_word] <= wr_data;
  end

endmodule

// File: rtl/dc_victim.sv
module dc_victim
  import dc_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 64,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] lock_base,
  input  logic             rand_mode,
  input  logic             advance,
  output logic [WAY_W-1:0] victim_way
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [WAY_W-1:0]  ptr_q [NUM_SETS];
  logic [WAY_W-1:0]  rand_way;
  logic [WAY_W-1:0]  rr_way;

  assign rand_way   = WAY_W'(rand_pick(32'(lfsr_q[WAY_W-1:0]), 32'(lock_base)));
  assign rr_way     = WAY_W'(rr_pick(32'(ptr_q[set_i]), 32'(lock_base)));
  assign victim_way = rand_mode ? rand_way : rr_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_step(lfsr_q);
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[s] <= '0;
      else if (advance && (set_i == SET_W'(s)))
        ptr_q[s] <= WAY_W'(rr_next(32'(victim_way), 32'(lock_base), NUM_WAYS));
    end
  end

endmodule

// File: rtl/cfg_dcache.sv
module cfg_dcache
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_SETS   = 4,
  parameter int NUM_WAYS   = 64,
  parameter int LINE_WORDS = 4,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int WRD_W     = $clog2(LINE_WORDS),
  localparam int BYTE_W    = $clog2(DATA_W / 8),
  localparam int OFF_W     = WRD_W + BYTE_W,
  localparam int TAG_W     = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              attr_cacheable,
  input  logic              attr_wback,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  input  logic              cfg_we,
  input  logic [WAY_W:0]    cfg_wdata,
  input  logic              inv_all,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  dc_state_e         state_q;
  logic              r_we, r_cach, r_wb;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, rdata_q;
  logic [WRD_W-1:0]  cnt_q;
  logic [WAY_W-1:0]  vway_q;
  logic [TAG_W-1:0]  vtag_q;
  logic              ack_q;
  logic              rand_q;
  logic [WAY_W-1:0]  lock_q;

  logic [SET_W-1:0]  r_set;
  logic [TAG_W-1:0]  r_tag;
  logic [WRD_W-1:0]  r_word;

  assign r_set  = r_addr[OFF_W +: SET_W];
  assign r_tag  = r_addr[ADDR_W-1 -: TAG_W];
  assign r_word = r_addr[BYTE_W +: WRD_W];

  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  logic              vq_valid, vq_dirty;
  logic [TAG_W-1:0]  vq_tag;
  logic              any_valid;
  logic [WAY_W-1:0]  victim_way;
  logic [DATA_W-1:0] ds_rd_data;

  // Named internal events
  logic in_look, look_hit, look_miss, rd_hit, wr_hit_wb, wr_hit_wt;
  logic fill_start, wr_miss, need_evict, last_word, fill_end, fill_beat;

  assign in_look    = (state_q == ST_LOOK);
  assign look_hit   = in_look && r_cach && lk_hit;
  assign look_miss  = in_look && r_cach && !lk_hit;
  assign rd_hit     = look_hit && !r_we;
  assign wr_hit_wb  = look_hit && r_we && r_wb;
  assign wr_hit_wt  = look_hit && r_we && !r_wb;
  assign fill_start = look_miss && !r_we;
  assign wr_miss    = look_miss && r_we;
  assign need_evict = vq_valid && vq_dirty;
  assign last_word  = (cnt_q == WRD_W'(LINE_WORDS - 1));
  assign fill_beat  = (state_q == ST_FILL) && mem_ack;
  assign fill_end   = fill_beat && last_word;

  // Configuration register: bit WAY_W random policy, low bits lock base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rand_q <= 1'b0;
      lock_q <= '0;
    end else if (cfg_we) begin
      rand_q <= cfg_wdata[WAY_W];
      lock_q <= cfg_wdata[WAY_W-1:0];
    end
  end

  dc_tag_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_all  (inv_all),
    .lk_set   (r_set),
    .lk_tag   (r_tag),
    .lk_hit   (lk_hit),
    .lk_way   (lk_way),
    .vq_way   (victim_way),
    .vq_valid (vq_valid),
    .vq_dirty (vq_dirty),
    .vq_tag   (vq_tag),
    .inst_en  (fill_end),
    .inst_way (vway_q),
    .inst_tag (r_tag),
    .drt_en   (wr_hit_wb),
    .drt_way  (lk_way),
    .any_valid(any_valid)
  );

  logic              ds_wr_en;
  logic [WAY_W-1:0]  ds_rd_way, ds_wr_way;
  logic [WRD_W-1:0]  ds_rd_word, ds_wr_word;
  logic [DATA_W-1:0] ds_wr_data;

  assign ds_rd_way  = (state_q == ST_EVICT) ? vway_q : lk_way;
  assign ds_rd_word = (state_q == ST_EVICT) ? cnt_q  : r_word;
  assign ds_wr_en   = fill_beat || wr_hit_wb || wr_hit_wt;
  assign ds_wr_way  = (state_q == ST_FILL) ? vway_q    : lk_way;
  assign ds_wr_word = (state_q == ST_FILL) ? cnt_q     : r_word;
  assign ds_wr_data = (state_q == ST_FILL) ? mem_rdata : r_wdata;

  dc_data_store #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
  ) u_data (
    .clk    (clk),
    .set_i  (r_set),
    .rd_way (ds_rd_way),
    .rd_word(ds_rd_word),
    .rd_data(ds_rd_data),
    .wr_en  (ds_wr_en),
    .wr_way (ds_wr_way),
    .wr_word(ds_wr_word),
    .wr_data(ds_wr_data)
  );

  dc_victim #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (r_set),
    .lock_base (lock_q),
    .rand_mode (rand_q),
    .advance   (fill_start),
    .victim_way(victim_way)
  );

  // Control sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      r_we    <= 1'b0;
      r_cach  <= 1'b0;
      r_wb    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
      vway_q  <= '0;
      vtag_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            r_we    <= cpu_we;
            r_addr  <= cpu_addr;
            r_wdata <= cpu_wdata;
            r_cach  <= attr_cacheable;
            r_wb    <= attr_wback;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!r_cach) begin
            state_q <= r_we ? ST_MWR : ST_MRD;
          end else if (lk_hit) begin
            if (!r_we) begin
              rdata_q <= ds_rd_data;
              ack_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else if (r_wb) begin
              ack_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_MWR;
            end
          end else if (r_we) begin
            state_q <= ST_MWR;
          end else begin
            vway_q  <= victim_way;
            vtag_q  <= vq_tag;
            cnt_q   <= '0;
            state_q <= need_evict ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: begin
          if (mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_word) begin
              cnt_q   <= '0;
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == r_word) rdata_q <= mem_rdata;
            if (last_word) begin
              cnt_q   <= '0;
              ack_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_MWR: begin
          if (mem_ack) begin
            ack_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_MRD: begin
          if (mem_ack) begin
            rdata_q <= mem_rdata;
            ack_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;

  assign mem_req = (state_q == ST_EVICT) || (state_q == ST_FILL) ||
                   (state_q == ST_MWR)   || (state_q == ST_MRD);
  assign mem_we  = (state_q == ST_EVICT) || (state_q == ST_MWR);

  always_comb begin
    unique case (state_q)
      ST_EVICT: mem_addr = {vtag_q, r_set, cnt_q, {BYTE_W{1'b0}}};
      ST_FILL:  mem_addr = {r_tag,  r_set, cnt_q, {BYTE_W{1'b0}}};
      default:  mem_addr = r_addr;
    endcase
  end
  assign mem_wdata = (state_q == ST_EVICT) ? ds_rd_data : r_wdata;

endmodule

// File: rtl/cfg_dcache_chk.sv
module cfg_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int WAY_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ack,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fill_start,
  input logic [WAY_W-1:0]  victim_way,
  input logic [WAY_W-1:0]  lock_q,
  input logic              inv_all,
  input logic              any_valid,
  input logic              wr_hit_wt,
  input logic              wr_miss
);

  assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_victim_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |-> (victim_way >= lock_q));

  assert_inv_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !any_valid);

  assert_wt_goes_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_wt |=> (mem_req && mem_we));

  assert_wmiss_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |=> (mem_req && mem_we));

endmodule

bind cfg_dcache cfg_dcache_chk #(.ADDR_W(ADDR_W), .WAY_W(WAY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ack   (cpu_ack),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .fill_start(fill_start),
  .victim_way(victim_way),
  .lock_q    (lock_q),
  .inv_all   (inv_all),
  .any_valid (any_valid),
  .wr_hit_wt (wr_hit_wt),
  .wr_miss   (wr_miss)
);

// File: tb/sim_cfg_dcache.sv
module sim_cfg_dcache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        attr_cacheable = 1'b0, attr_wback = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_ack;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic        inv_tb = 1'b0, inv_mod = 1'b0;
  logic        inv_all;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  assign inv_all = inv_tb | inv_mod;

  cfg_dcache u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .attr_cacheable(attr_cacheable), .attr_wback(attr_wback),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .inv_all(inv_all), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial forever #5 clk = ~clk;

  int total = 0, errs = 0;
  int nrd = 0, nwr = 0, nlog = 0;
  logic [31:0] log_a [16];
  logic        log_w [16];
  logic [31:0] bmem [4096];
  logic        inv_arm = 1'b0;
  logic [31:0] rd;
  int          lat;

  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return 32'((t << 6) | (s << 4) | (w << 2));
  endfunction

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return 32'hC0DE_0000 + 32'(a[13:2]) * 3;
  endfunction

  // Memory model: one word per acknowledge, acknowledge one cycle after request
  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = init_val(32'(i << 2));
    forever begin
      @(posedge clk);
      inv_mod <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (nlog < 16) begin
          log_a[nlog] = mem_addr;
          log_w[nlog] = mem_we;
        end
        nlog++;
        if (mem_we) begin
          bmem[mem_addr[13:2]] = mem_wdata;
          nwr++;
        end else begin
          mem_rdata <= bmem[mem_addr[13:2]];
          nrd++;
          if (inv_arm && (mem_addr[3:2] == 2'd3)) begin
            inv_mod <= 1'b1;
            inv_arm = 1'b0;
          end
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++;
    errs++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic c, input logic wb);
    @(negedge clk);
    nrd = 0; nwr = 0; nlog = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    attr_cacheable = c; attr_wback = wb;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_ack && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    if (!cpu_ack) chk("R12 ack timeout", 32'd0, 32'd1);
    rd = cpu_rdata;
  endtask

  task automatic set_cfg(input logic rnd, input int lock);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {rnd, 6'(lock)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_inv();
    @(negedge clk);
    inv_tb = 1'b1;
    @(negedge clk);
    inv_tb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 ack after reset", 32'(cpu_ack), 32'd0);
    chk("R13 mem_req after reset", 32'(mem_req), 32'd0);
  endtask

  // Line A lands in way 63 of set 0 (lock 63, round-robin)
  task automatic t_fill_and_hit();
    logic [31:0] a;
    a = mk(1, 0, 2);
    access(1'b0, a, '0, 1'b1, 1'b1);
    chk("R2 fill read count", 32'(nrd), 32'd4);
    chk("R2 fill data", rd, init_val(a));
    for (int i = 0; i < 4; i++) begin
      chk("R12 R2 fill word order", log_a[i], mk(1, 0, i));
      chk("R12 fill is read", 32'(log_w[i]), 32'd0);
    end
    access(1'b0, mk(1, 0, 0), '0, 1'b1, 1'b1);
    chk("R1 hit no transfer", 32'(nrd + nwr), 32'd0);
    chk("R1 hit latency", 32'(lat), 32'd2);
    chk("R1 hit data", rd, init_val(mk(1, 0, 0)));
    access(1'b0, mk(1, 0, 3), '0, 1'b1, 1'b1);
    chk("R1 hit data word3", rd, init_val(mk(1, 0, 3)));
  endtask

  task automatic t_write_back();
    access(1'b1, mk(1, 0, 1), 32'h1111_2222, 1'b1, 1'b1);
    chk("R3 wb hit no transfer", 32'(nrd + nwr), 32'd0);
    chk("R3 memory untouched", bmem[mk(1, 0, 1) >> 2], init_val(mk(1, 0, 1)));
    access(1'b0, mk(1, 0, 1), '0, 1'b1, 1'b1);
    chk("R3 readback", rd, 32'h1111_2222);
    access(1'b0, mk(2, 0, 0), '0, 1'b1, 1'b1);
    chk("R4 dirty evict writes", 32'(nwr), 32'd4);
    chk("R4 refill reads", 32'(nrd), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 writes first", 32'(log_w[i]), 32'd1);
      chk("R4 write order", log_a[i], mk(1, 0, i));
      chk("R4 reads after", 32'(log_w[i + 4]), 32'd0);
    end
    chk("R4 modified word stored", bmem[mk(1, 0, 1) >> 2], 32'h1111_2222);
  endtask

  task automatic t_write_through();
    access(1'b1, mk(2, 0, 0), 32'h3333_4444, 1'b1, 1'b0);
    chk("R5 wt one write", 32'(nwr), 32'd1);
    chk("R5 wt no read", 32'(nrd), 32'd0);
    chk("R5 memory updated", bmem[mk(2, 0, 0) >> 2], 32'h3333_4444);
    access(1'b0, mk(2, 0, 0), '0, 1'b1, 1'b0);
    chk("R5 line updated", rd, 32'h3333_4444);
    chk("R5 readback hit", 32'(nrd), 32'd0);
    access(1'b0, mk(3, 0, 0), '0, 1'b1, 1'b0);
    chk("R5 clean evict no write", 32'(nwr), 32'd0);
  endtask

  task automatic t_write_miss();
    access(1'b1, mk(4, 1, 2), 32'h5555_6666, 1'b1, 1'b1);
    chk("R6 miss one write", 32'(nwr), 32'd1);
    chk("R6 miss no fill", 32'(nrd), 32'd0);
    access(1'b0, mk(4, 1, 2), '0, 1'b1, 1'b1);
    chk("R6 not allocated", 32'(nrd), 32'd4);
    chk("R6 data", rd, 32'h5555_6666);
  endtask

  task automatic t_uncached();
    access(1'b0, mk(5, 2, 1), '0, 1'b0, 1'b0);
    chk("R7 single read", 32'(nrd), 32'd1);
    chk("R7 data", rd, init_val(mk(5, 2, 1)));
    access(1'b0, mk(5, 2, 1), '0, 1'b0, 1'b0);
    chk("R7 repeat goes out", 32'(nrd), 32'd1);
    access(1'b1, mk(5, 2, 1), 32'h7777_8888, 1'b0, 1'b1);
    chk("R7 single write", 32'(nwr), 32'd1);
    access(1'b0, mk(5, 2, 1), '0, 1'b0, 1'b0);
    chk("R7 read new", rd, 32'h7777_8888);
  endtask

  task automatic t_round_robin_lock();
    set_cfg(1'b0, 0);
    access(1'b0, mk(10, 3, 0), '0, 1'b1, 1'b1);
    access(1'b0, mk(11, 3, 0), '0, 1'b1, 1'b1);
    set_cfg(1'b0, 60);
    for (int i = 0; i < 5; i++) begin
      access(1'b0, mk(20 + i, 3, 0), '0, 1'b1, 1'b1);
      chk("R8 churn miss", 32'(nrd), 32'd4);
    end
    for (int i = 1; i < 5; i++) begin
      access(1'b0, mk(20 + i, 3, 0), '0, 1'b1, 1'b1);
      chk("R8 survivor hit", 32'(nrd), 32'd0);
    end
    access(1'b0, mk(10, 3, 0), '0, 1'b1, 1'b1);
    chk("R10 locked way0 kept", 32'(nrd), 32'd0);
    access(1'b0, mk(11, 3, 0), '0, 1'b1, 1'b1);
    chk("R10 locked way1 kept", 32'(nrd), 32'd0);
    access(1'b0, mk(20, 3, 0), '0, 1'b1, 1'b1);
    chk("R8 first victim evicted", 32'(nrd), 32'd4);
    access(1'b0, mk(21, 3, 0), '0, 1'b1, 1'b1);
    chk("R8 next way replaced", 32'(nrd), 32'd4);
  endtask

  task automatic t_random();
    set_cfg(1'b0, 0);
    access(1'b0, mk(30, 2, 0), '0, 1'b1, 1'b1);
    set_cfg(1'b1, 1);
    for (int i = 0; i < 20; i++) begin
      access(1'b0, mk(40 + i, 2, 0), '0, 1'b1, 1'b1);
      chk("R9 random miss fills", 32'(nrd), 32'd4);
    end
    access(1'b0, mk(30, 2, 0), '0, 1'b1, 1'b1);
    chk("R9 R10 locked line kept", 32'(nrd), 32'd0);
    set_cfg(1'b1, 63);
    access(1'b0, mk(80, 2, 0), '0, 1'b1, 1'b1);
    access(1'b0, mk(81, 2, 0), '0, 1'b1, 1'b1);
    access(1'b0, mk(80, 2, 0), '0, 1'b1, 1'b1);
    chk("R9 clamp to way 63", 32'(nrd), 32'd4);
  endtask

  task automatic t_invalidate();
    access(1'b0, mk(60, 1, 0), '0, 1'b1, 1'b1);
    access(1'b0, mk(60, 1, 0), '0, 1'b1, 1'b1);
    chk("R11 cached before", 32'(nrd), 32'd0);
    pulse_inv();
    access(1'b0, mk(60, 1, 0), '0, 1'b1, 1'b1);
    chk("R11 miss after invalidate", 32'(nrd), 32'd4);
    access(1'b1, mk(60, 1, 0), 32'h9999_AAAA, 1'b1, 1'b1);
    pulse_inv();
    access(1'b0, mk(60, 1, 0), '0, 1'b1, 1'b1);
    chk("R11 dirty discarded no write", 32'(nwr), 32'd0);
    chk("R11 old data from memory", rd, init_val(mk(60, 1, 0)));
  endtask

  task automatic t_inv_with_fill();
    inv_arm = 1'b1;
    access(1'b0, mk(70, 0, 1), '0, 1'b1, 1'b1);
    chk("R11 data during collision", rd, init_val(mk(70, 0, 1)));
    access(1'b0, mk(70, 0, 1), '0, 1'b1, 1'b1);
    chk("R11 invalidate beat install", 32'(nrd), 32'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    set_cfg(1'b0, 63);
    t_fill_and_hit();
    t_write_back();
    t_write_through();
    t_write_miss();
    t_uncached();
    t_round_robin_lock();
    t_random();
    t_invalidate();
    t_inv_with_fill();
    repeat (4) @(negedge clk);
    summary();
  end

endmodule